// File: doc/BRIEF.md
# Full-Bridge Gate Control Sequencer

This block is the synchronous control core of an H-bridge gate driver. It reads a single direction bit, a high-side enable, a disable request and an undervoltage flag. From these it produces four registered gate commands, one for each switch: A-low, A-high, B-low and B-high. Each command turns on only after a programmable delay, with one setting shared by the two high-side switches and another shared by the two low-side switches. Every command turns off on the first clock edge after its request goes away. This sequencing gives dead time on turn-on only.

Disable and undervoltage both force all four commands low. When both are released, a start-up sequence runs. First, both low-side switches turn on together for a programmed number of cycles so that the bootstrap capacitors recharge. The high-side switches then stay blocked until a longer programmed interval, counted from the release, has elapsed. The direction bit passes through a qualifier before it is acted on: a change to 1 must be held for `RISE_QUAL` clock samples and a change to 0 for `FALL_QUAL` samples. All delays and widths are clock-cycle counts on configuration inputs.

Top module: `hbridge_gate_seq`

## Requirements
- R1: When the qualified direction is 1, A-high and B-low are the active pair and A-low and B-high are off. When it is 0, A-low and B-high are active and A-high and B-low are off. The bench observes the gate vector in the order {A-low, A-high, B-low, B-high}.
- R2: A sampled disable high drives all four gates low on that clock edge. While disable stays high, the gates stay low whatever the other inputs do.
- R3: A sampled undervoltage flag forces all gates low in the same way as disable. Releasing it starts the same refresh sequence as releasing disable.
- R4: While the high-side enable is low, both high-side gates are low. The low-side gates still follow the qualified direction, so the load freewheels through the bottom switches.
- R5: A gate whose request appears at edge k turns on at edge k+D. D is `hs_dly_i` for the high-side gates and `ls_dly_i` for the low-side gates. A gate whose request disappears is low after the next edge.
- R6: Release from disable or undervoltage is sampled at edge E1. Both low-side gates are then on from edge E2 for `refresh_len_i` cycles (at least one), with no turn-on delay applied.
- R7: Counting from edge E1, no high-side gate may request turn-on until `upper_len_i` cycles have elapsed. Until then, the low-side gates follow the direction bit.
- R8: A change of the raw direction bit to 1 takes effect only after it has been sampled on `RISE_QUAL` consecutive edges (default 3). A change to 0 needs `FALL_QUAL` consecutive edges (default 2). Shorter pulses have no effect on the gates.
- R9: A direction change during a pending turn-on delay cancels that turn-on, and the delay restarts for the newly selected pair.
- R10: A-low and A-high are never high in the same cycle, and B-low and B-high are never high in the same cycle.
- R11: While `rst_n` is low, the block is in the disabled state with all gates low.
- R12: A delay setting of 0 turns the gate on at the first edge that samples its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Raw direction/PWM bit |
| hi_en_i | input | 1 | High-side enable, low forces high sides off |
| dis_i | input | 1 | Disable request, forces all gates off |
| uv_i | input | 1 | Undervoltage flag, forces all gates off |
| hs_dly_i | input | DLY_W | High-side turn-on delay in cycles |
| ls_dly_i | input | DLY_W | Low-side turn-on delay in cycles |
| refresh_len_i | input | DLY_W | Refresh pulse length in cycles |
| upper_len_i | input | DLY_W | Cycles from release before high sides may turn on |
| gate_al_o | output | 1 | A-low gate command |
| gate_ah_o | output | 1 | A-high gate command |
| gate_bl_o | output | 1 | B-low gate command |
| gate_bh_o | output | 1 | B-high gate command |

## Verification
Every gate responds to disable, undervoltage and a withdrawn high-side enable one edge after the input is sampled. A raw direction change first needs `RISE_QUAL` or `FALL_QUAL` edges to be accepted. The old pair then drops on the next edge, and the new pair turns on `hs_dly_i` or `ls_dly_i` edges after that. On release, the refresh pair appears on the second edge and the first high-side request is sampled on edge `upper_len_i`+2. The bench drives and samples one nanosecond after each rising edge, and counts edges from each stimulus to the exact cycle computed above. It checks one edge before a change as well as the edge of the change, which catches off-by-one errors in either direction.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

  typedef enum logic [1:0] {
    WK_OFF     = 2'd0,
    WK_REFRESH = 2'd1,
    WK_HOLD    = 2'd2,
    WK_RUN     = 2'd3
  } wake_state_t;

  localparam int unsigned GATE_N = 4;
  localparam int unsigned G_AL   = 0;
  localparam int unsigned G_AH   = 1;
  localparam int unsigned G_BL   = 2;
  localparam int unsigned G_BH   = 3;

endpackage

// File: rtl/hb_dir_qual.sv
module hb_dir_qual #(
  parameter int unsigned RISE_QUAL = 3,
  parameter int unsigned FALL_QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic dir_o
);
  localparam int unsigned QMAX = (RISE_QUAL > FALL_QUAL) ? RISE_QUAL : FALL_QUAL;
  localparam int unsigned CW   = $clog2(QMAX + 2);

  logic          acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] need;
  logic [CW-1:0] cnt_inc;

  always_comb begin
    need    = raw_i ? CW'(RISE_QUAL) : CW'(FALL_QUAL);
    cnt_inc = cnt_q + 1'b1;
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    if (raw_i == acc_q) begin
      cnt_d = '0;
    end else if (cnt_inc >= need) begin
      acc_d = raw_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign dir_o = acc_q;

endmodule

// File: rtl/hb_wake_seq.sv
module hb_wake_seq
  import hbridge_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_i,
  input  logic [DLY_W-1:0] refresh_len_i,
  input  logic [DLY_W-1:0] upper_len_i,
  output wake_state_t      state_o
);
  wake_state_t      st_q, st_d;
  logic [DLY_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;

  always_comb begin
    st_d   = st_q;
    tmr_en = (st_q == WK_REFRESH) || (st_q == WK_HOLD);
    tmr_d  = tmr_q;
    if (tmr_en && !(&tmr_q)) begin
      tmr_d = tmr_q + 1'b1;
    end
    case (st_q)
      WK_OFF: begin
        st_d  = WK_REFRESH;
        tmr_d = DLY_W'(1);
      end
      WK_REFRESH: begin
        if (tmr_q >= refresh_len_i) begin
          st_d = (tmr_q >= upper_len_i) ? WK_RUN : WK_HOLD;
        end
      end
      WK_HOLD: begin
        if (tmr_q >= upper_len_i) begin
          st_d = WK_RUN;
        end
      end
      default: st_d = st_q;
    endcase
    if (kill_i) begin
      st_d  = WK_OFF;
      tmr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WK_OFF;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/hb_turnon_cell.sv
module hb_turnon_cell #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want_i,
  input  logic             bypass_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             gate_o
);
  logic             gate_q, gate_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    gate_d = gate_q;
    cnt_d  = cnt_q;
    if (!want_i) begin
      gate_d = 1'b0;
      cnt_d  = '0;
    end else if (gate_q) begin
      cnt_d  = '0;
    end else if (bypass_i || (cnt_q >= dly_i)) begin
      gate_d = 1'b1;
      cnt_d  = '0;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbridge_pkg::*;
#(
  parameter int unsigned DLY_W     = 8,
  parameter int unsigned RISE_QUAL = 3,
  parameter int unsigned FALL_QUAL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_i,
  input  logic             hi_en_i,
  input  logic             dis_i,
  input  logic             uv_i,
  input  logic [DLY_W-1:0] hs_dly_i,
  input  logic [DLY_W-1:0] ls_dly_i,
  input  logic [DLY_W-1:0] refresh_len_i,
  input  logic [DLY_W-1:0] upper_len_i,
  output logic             gate_al_o,
  output logic             gate_ah_o,
  output logic             gate_bl_o,
  output logic             gate_bh_o
);
  logic              kill;
  logic              dir_q;
  wake_state_t       wstate;
  logic              lows_ok, highs_ok, refresh;
  logic [GATE_N-1:0] want, bypass, gates;

  assign kill = dis_i | uv_i;

  hb_dir_qual #(
    .RISE_QUAL (RISE_QUAL),
    .FALL_QUAL (FALL_QUAL)
  ) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (dir_i),
    .dir_o (dir_q)
  );

  hb_wake_seq #(.DLY_W(DLY_W)) u_wake (
    .clk           (clk),
    .rst_n         (rst_n),
    .kill_i        (kill),
    .refresh_len_i (refresh_len_i),
    .upper_len_i   (upper_len_i),
    .state_o       (wstate)
  );

  always_comb begin
    refresh  = (wstate == WK_REFRESH);
    lows_ok  = (wstate == WK_HOLD) || (wstate == WK_RUN);
    highs_ok = (wstate == WK_RUN) && hi_en_i;
    want[G_AL]   = !kill && (refresh || (lows_ok && !dir_q));
    want[G_BL]   = !kill && (refresh || (lows_ok &&  dir_q));
    want[G_AH]   = !kill && highs_ok &&  dir_q;
    want[G_BH]   = !kill && highs_ok && !dir_q;
    bypass[G_AL] = refresh;
    bypass[G_BL] = refresh;
    bypass[G_AH] = 1'b0;
    bypass[G_BH] = 1'b0;
  end

  for (genvar g = 0; g < GATE_N; g++) begin : g_cell
    localparam bit IS_HIGH = (g == G_AH) || (g == G_BH);
    logic [DLY_W-1:0] dly_sel;
    if (IS_HIGH) begin : g_hi
      assign dly_sel = hs_dly_i;
    end else begin : g_lo
      assign dly_sel = ls_dly_i;
    end
    hb_turnon_cell #(.DLY_W(DLY_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .want_i   (want[g]),
      .bypass_i (bypass[g]),
      .dly_i    (dly_sel),
      .gate_o   (gates[g])
    );
  end

  assign gate_al_o = gates[G_AL];
  assign gate_ah_o = gates[G_AH];
  assign gate_bl_o = gates[G_BL];
  assign gate_bh_o = gates[G_BH];

endmodule

// File: rtl/hbridge_gate_seq_chk.sv
module hbridge_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic hi_en_i,
  input logic dis_i,
  input logic uv_i,
  input logic gate_al_o,
  input logic gate_ah_o,
  input logic gate_bl_o,
  input logic gate_bh_o
);

  AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_al_o && gate_ah_o)); // R10

  AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_bl_o && gate_bh_o)); // R10

  AST_DIS_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |=> !(gate_al_o || gate_ah_o || gate_bl_o || gate_bh_o)); // R2

  AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> !(gate_al_o || gate_ah_o || gate_bl_o || gate_bh_o)); // R3

  AST_CHOP_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en_i |=> !(gate_ah_o || gate_bh_o)); // R4

  AST_HIGH_RISE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_ah_o) || $rose(gate_bh_o)) |-> $past(hi_en_i && !dis_i && !uv_i)); // R7

endmodule

bind hbridge_gate_seq hbridge_gate_seq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hi_en_i   (hi_en_i),
  .dis_i     (dis_i),
  .uv_i      (uv_i),
  .gate_al_o (gate_al_o),
  .gate_ah_o (gate_ah_o),
  .gate_bl_o (gate_bl_o),
  .gate_bh_o (gate_bh_o)
);

// File: tb/test_hbridge_gate_seq.sv
`timescale 1ns/1ps
module test_hbridge_gate_seq;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dir_i, hi_en_i, dis_i, uv_i;
  logic [DW-1:0] hs_dly_i, ls_dly_i, refresh_len_i, upper_len_i;
  logic          gate_al_o, gate_ah_o, gate_bl_o, gate_bh_o;

  int n_chk = 0;
  int n_err = 0;
  int leg_viol = 0;

  always #2 clk = ~clk;

  hbridge_gate_seq #(.DLY_W(DW), .RISE_QUAL(3), .FALL_QUAL(2)) i_hbridge_gate_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .dir_i         (dir_i),
    .hi_en_i       (hi_en_i),
    .dis_i         (dis_i),
    .uv_i          (uv_i),
    .hs_dly_i      (hs_dly_i),
    .ls_dly_i      (ls_dly_i),
    .refresh_len_i (refresh_len_i),
    .upper_len_i   (upper_len_i),
    .gate_al_o     (gate_al_o),
    .gate_ah_o     (gate_ah_o),
    .gate_bl_o     (gate_bl_o),
    .gate_bh_o     (gate_bh_o)
  );

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      if ((gate_al_o && gate_ah_o) || (gate_bl_o && gate_bh_o)) leg_viol++;
    end
  endtask

  // expected order {al, ah, bl, bh}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {gate_al_o, gate_ah_o, gate_bl_o, gate_bh_o};
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: gates{al,ah,bl,bh} got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; dis_i = 1'b1; uv_i = 1'b0; dir_i = 1'b0; hi_en_i = 1'b1;
    hs_dly_i = 8'd3; ls_dly_i = 8'd2; refresh_len_i = 8'd5; upper_len_i = 8'd8;
    tick(3);
    chk("R11 reset all off", 4'b0000);
    rst_n = 1'b1;
    tick(3);
    chk("R2 disabled after reset", 4'b0000);
  endtask

  task automatic t_release();
    dis_i = 1'b0;
    tick(1); chk("R6 first edge after release", 4'b0000);
    tick(1); chk("R6 refresh lows on", 4'b1010);
    tick(4); chk("R6 refresh last cycle", 4'b1010);
    tick(1); chk("R6 refresh ended, dir0 low stays", 4'b1000);
    tick(5); chk("R7 high side still blocked", 4'b1000);
    tick(1); chk("R7 R1 B-high on, dir0 pair", 4'b1001);
  endtask

  task automatic t_dir_rise();
    dir_i = 1'b1;
    tick(3); chk("R8 rise not yet accepted", 4'b1001);
    tick(1); chk("R5 old pair off at once", 4'b0000);
    tick(1); chk("R5 low delay counting", 4'b0000);
    tick(1); chk("R5 B-low on after ls delay", 4'b0010);
    tick(1); chk("R1 R5 A-high on after hs delay", 4'b0110);
  endtask

  task automatic t_glitch();
    dir_i = 1'b0;
    tick(1);
    dir_i = 1'b1;
    tick(4); chk("R8 short pulse ignored", 4'b0110);
  endtask

  task automatic t_cancel();
    dir_i = 1'b0;
    tick(2); chk("R8 fall accepted, outputs one edge later", 4'b0110);
    dir_i = 1'b1;
    tick(1); chk("R5 dir1 pair off", 4'b0000);
    tick(2); chk("R5 A-low on after ls delay", 4'b1000);
    tick(1); chk("R9 B-high turn-on cancelled", 4'b0000);
    tick(2); chk("R9 B-low restarted delay", 4'b0010);
    tick(1); chk("R9 A-high restarted delay", 4'b0110);
  endtask

  task automatic t_chop();
    hi_en_i = 1'b0;
    tick(1); chk("R4 high off, low stays", 4'b0010);
    dir_i = 1'b0;
    tick(3); chk("R4 lows switch with direction", 4'b0000);
    tick(2); chk("R4 freewheel through A-low", 4'b1000);
    hi_en_i = 1'b1;
    tick(3); chk("R5 high delay after enable", 4'b1000);
    tick(1); chk("R4 B-high back on", 4'b1001);
  endtask

  task automatic t_zero_delay();
    hs_dly_i = 8'd0; ls_dly_i = 8'd0;
    dir_i = 1'b1;
    tick(3); chk("R12 before accepted change", 4'b1001);
    tick(1); chk("R12 zero delay swap", 4'b0110);
    hs_dly_i = 8'd3; ls_dly_i = 8'd2;
  endtask

  task automatic t_disable();
    dis_i = 1'b1;
    tick(1); chk("R2 disable forces off", 4'b0000);
    dir_i = 1'b0; hi_en_i = 1'b0;
    tick(2); hi_en_i = 1'b1;
    tick(2); chk("R2 disable overrides inputs", 4'b0000);
    dis_i = 1'b0;
    tick(2);  chk("R6 refresh after disable", 4'b1010);
    tick(11); chk("R7 run after upper interval", 4'b1001);
  endtask

  task automatic t_uv();
    uv_i = 1'b1;
    tick(1); chk("R3 undervoltage forces off", 4'b0000);
    dir_i = 1'b1;
    tick(3); chk("R3 held off under undervoltage", 4'b0000);
    uv_i = 1'b0;
    tick(2); chk("R3 refresh after undervoltage", 4'b1010);
  endtask

  task automatic t_reset_mid();
    tick(12);
    rst_n = 1'b0;
    #1; chk("R11 async reset clears gates", 4'b0000);
    tick(2); chk("R11 held in reset", 4'b0000);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_release();
    t_dir_rise();
    t_glitch();
    t_cancel();
    t_chop();
    t_zero_delay();
    t_disable();
    t_uv();
    t_reset_mid();
    n_chk++;
    if (leg_viol != 0) begin
      n_err++;
      $display("FAIL R10 leg conflict cycles: got %0d expected 0", leg_viol);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule